// File: doc/BRIEF.md
# Output Compare Pin Action Unit

This block holds the compare side of a multi-channel timer. Each channel compares a shared free-running count against its own compare value. On a match it raises a sticky flag and applies a 2-bit action to its own output pin: leave the pin alone, toggle it, drive it low or drive it high. The counter itself and the input capture path sit outside this block. The count arrives as an input, together with a one-cycle strobe that marks each increment and a one-cycle overflow strobe.

The highest-numbered channel is the lead channel. When its compare event occurs, it drives a masked group of pins (any of them, its own included) to fixed data levels. The lead channel wins over any other action on the same pin in the same cycle.

A force input triggers a channel's compare action without a match and without touching its flag. A per-pin option toggles the pin whenever the counter overflows. A channel marked for capture takes no compare action at all. A single interrupt line is the OR of every flag whose enable bit is set.

Top module: `oc_pin_action_unit`

## Requirements
- R1: Action code per pin i is act_code_i[2i+1:2i], mode bit high: 01 toggles the pin, 10 drives it to 0, 11 drives it to 1. The action takes effect on the clock edge that samples a compare event. A match is tick_i high, count_i equal to channel i's compare value cmp_val_i[16i+:16], and cmp_mode_i[i]=1.
- R2: With action code 00 the pin keeps its level on its own channel's events. pin_oe_o[i] is low exactly when the code is 00 and lead_mask_i[i] is 0; otherwise it is high.
- R3: A match sets flag_o[i] at the next edge. The flag then holds until flag_clr_i[i] is high at an edge. A match and a clear in the same cycle leave the flag set.
- R4: With tick_i low no match occurs, even if count_i equals the compare value, so a held count neither raises a flag nor repeats an action.
- R5: force_i[i] high with cmp_mode_i[i]=1 performs channel i's pin action at the next edge and does not set flag_o[i].
- R6: A compare event (match or force) on the lead channel NCH-1 drives every pin i with lead_mask_i[i]=1 to lead_data_i[i].
- R7: If a lead-channel masked action and a pin's own action fall on the same pin in the same cycle, the lead-channel data wins.
- R8: With tog_ovf_i[i]=1, an ovf_i pulse toggles pin i, unless a compare action hits that pin in the same cycle; the compare action wins.
- R9: A channel with cmp_mode_i[i]=0 (capture) sets no flag and performs no pin action from matches or forces. If it is the lead channel, it drives no masked pins.
- R10: irq_o is high when any flag_o[i] and irq_en_i[i] are both high.
- R11: After reset all pins and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | CW | Shared timer count |
| tick_i | input | 1 | High in the cycle count_i shows a freshly incremented value |
| ovf_i | input | 1 | Counter overflow pulse |
| cmp_val_i | input | NCH*CW | Compare values, channel i at [CW*i +: CW] |
| cmp_mode_i | input | NCH | 1 = compare channel, 0 = capture channel |
| act_code_i | input | 2*NCH | Pin action codes, channel i at [2i+1:2i] |
| force_i | input | NCH | Force compare action pulse |
| lead_mask_i | input | NCH | Pins driven by the lead channel |
| lead_data_i | input | NCH | Levels driven by the lead channel |
| tog_ovf_i | input | NCH | Toggle pin on overflow |
| irq_en_i | input | NCH | Flag interrupt enables |
| flag_clr_i | input | NCH | Flag clear pulse |
| pin_o | output | NCH | Pin levels |
| pin_oe_o | output | NCH | Pin output enables |
| flag_o | output | NCH | Compare flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check these properties on every cycle:
- every match sets its flag (R3);
- a flag never rises without an increment strobe (R4);
- a force alone leaves the flag clear (R5);
- capture channels never raise flags (R9);
- a masked pin takes the lead data after a lead event (R6);
- a drive-low code yields a low pin (R1).

The directed scenarios in the bench cover the rest:
- the toggle and drive-high codes;
- the precedence among lead, own and overflow actions (R7, R8);
- output-enable gating (R2);
- set-over-clear on flags (R3);
- interrupt masking (R10).

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [1:0] {
    ACT_OFF = 2'b00,
    ACT_TOG = 2'b01,
    ACT_LO  = 2'b10,
    ACT_HI  = 2'b11
  } oc_act_e;

  function automatic logic apply_act(oc_act_e act, logic cur);
    case (act)
      ACT_TOG: return ~cur;
      ACT_LO:  return 1'b0;
      ACT_HI:  return 1'b1;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/oc_match_unit.sv
`timescale 1ns/1ps
module oc_match_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic [CW-1:0]     count_i,
  input  logic              tick_i,
  input  logic [NCH*CW-1:0] cmp_val_i,
  input  logic [NCH-1:0]    cmp_mode_i,
  input  logic [NCH-1:0]    force_i,
  output logic [NCH-1:0]    hit_o,
  output logic [NCH-1:0]    evt_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic eq;
    assign eq       = (count_i == cmp_val_i[CW*g +: CW]);
    // match only on an increment strobe
    assign hit_o[g] = cmp_mode_i[g] & tick_i & eq;
    assign evt_o[g] = cmp_mode_i[g] & ((tick_i & eq) | force_i[g]);
  end
endmodule

// File: rtl/oc_pin_ctrl.sv
`timescale 1ns/1ps
module oc_pin_ctrl
  import oc_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   evt_i,
  input  logic [2*NCH-1:0] act_code_i,
  input  logic [NCH-1:0]   lead_mask_i,
  input  logic [NCH-1:0]   lead_data_i,
  input  logic             ovf_i,
  input  logic [NCH-1:0]   tog_ovf_i,
  output logic [NCH-1:0]   pin_o,
  output logic [NCH-1:0]   pin_oe_o
);
  localparam int LEAD = NCH - 1;

  logic lead_evt;
  assign lead_evt = evt_i[LEAD];

  for (genvar g = 0; g < NCH; g++) begin : g_pin
    oc_act_e act;
    logic    nxt;
    assign act = oc_act_e'(act_code_i[2*g +: 2]);

    // priority: lead mask > own action > overflow toggle
    always_comb begin
      nxt = pin_o[g];
      if (lead_evt && lead_mask_i[g])     nxt = lead_data_i[g];
      else if (evt_i[g] && act != ACT_OFF) nxt = apply_act(act, pin_o[g]);
      else if (ovf_i && tog_ovf_i[g])     nxt = ~pin_o[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_o[g] <= 1'b0;
      else         pin_o[g] <= nxt;
    end

    assign pin_oe_o[g] = (act != ACT_OFF) | lead_mask_i[g];
  end
endmodule

// File: rtl/oc_flag_bank.sv
`timescale 1ns/1ps
module oc_flag_bank #(
  parameter int NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] hit_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] en_i,
  output logic [NCH-1:0] flag_o,
  output logic           irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= hit_i | (flag_o & ~clr_i); // set wins
  end

  assign irq_o = |(flag_o & en_i);
endmodule

// File: rtl/oc_pin_action_unit.sv
`timescale 1ns/1ps
module oc_pin_action_unit #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     count_i,
  input  logic              tick_i,
  input  logic              ovf_i,
  input  logic [NCH*CW-1:0] cmp_val_i,
  input  logic [NCH-1:0]    cmp_mode_i,
  input  logic [2*NCH-1:0]  act_code_i,
  input  logic [NCH-1:0]    force_i,
  input  logic [NCH-1:0]    lead_mask_i,
  input  logic [NCH-1:0]    lead_data_i,
  input  logic [NCH-1:0]    tog_ovf_i,
  input  logic [NCH-1:0]    irq_en_i,
  input  logic [NCH-1:0]    flag_clr_i,
  output logic [NCH-1:0]    pin_o,
  output logic [NCH-1:0]    pin_oe_o,
  output logic [NCH-1:0]    flag_o,
  output logic              irq_o
);
  logic [NCH-1:0] hit, evt;

  oc_match_unit #(.NCH(NCH), .CW(CW)) match_i (
    .count_i(count_i), .tick_i(tick_i), .cmp_val_i(cmp_val_i),
    .cmp_mode_i(cmp_mode_i), .force_i(force_i),
    .hit_o(hit), .evt_o(evt)
  );

  oc_pin_ctrl #(.NCH(NCH)) pins_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt), .act_code_i(act_code_i),
    .lead_mask_i(lead_mask_i), .lead_data_i(lead_data_i),
    .ovf_i(ovf_i), .tog_ovf_i(tog_ovf_i),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o)
  );

  oc_flag_bank #(.NCH(NCH)) flags_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .clr_i(flag_clr_i),
    .en_i(irq_en_i), .flag_o(flag_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/oc_pin_action_chk.sv
`timescale 1ns/1ps
module oc_pin_action_chk #(
  parameter int NCH = 8,
  parameter int CW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CW-1:0]     count_i,
  input logic              tick_i,
  input logic              ovf_i,
  input logic [NCH*CW-1:0] cmp_val_i,
  input logic [NCH-1:0]    cmp_mode_i,
  input logic [2*NCH-1:0]  act_code_i,
  input logic [NCH-1:0]    force_i,
  input logic [NCH-1:0]    lead_mask_i,
  input logic [NCH-1:0]    lead_data_i,
  input logic [NCH-1:0]    tog_ovf_i,
  input logic [NCH-1:0]    irq_en_i,
  input logic [NCH-1:0]    flag_clr_i,
  input logic [NCH-1:0]    pin_o,
  input logic [NCH-1:0]    pin_oe_o,
  input logic [NCH-1:0]    flag_o,
  input logic              irq_o
);
  localparam int LEAD = NCH - 1;

  logic [NCH-1:0] eqv;
  for (genvar g = 0; g < NCH; g++) begin : g_eq
    assign eqv[g] = (count_i == cmp_val_i[CW*g +: CW]);
  end

  logic lead_fire;
  assign lead_fire = cmp_mode_i[LEAD] & ((tick_i & eqv[LEAD]) | force_i[LEAD]);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    assert_match_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_mode_i[g] && tick_i && eqv[g]) |=> flag_o[g]);

    assert_no_tick_no_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !flag_o[g]) |=> !flag_o[g]);

    assert_force_no_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (force_i[g] && !flag_o[g] && !(tick_i && eqv[g])) |=> !flag_o[g]);

    assert_capture_no_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cmp_mode_i[g] && !flag_o[g]) |=> !flag_o[g]);

    assert_lead_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lead_fire && lead_mask_i[g]) |=> (pin_o[g] == $past(lead_data_i[g])));

    assert_drive_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmp_mode_i[g] && ((tick_i && eqv[g]) || force_i[g]) &&
       act_code_i[2*g +: 2] == 2'b10 && !(lead_fire && lead_mask_i[g])) |=> !pin_o[g]);
  end

  logic unused_ok;
  assign unused_ok = ^{ovf_i, tog_ovf_i, irq_en_i, flag_clr_i, pin_oe_o, irq_o};
endmodule

bind oc_pin_action_unit oc_pin_action_chk #(.NCH(NCH), .CW(CW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_i), .tick_i(tick_i),
  .ovf_i(ovf_i), .cmp_val_i(cmp_val_i), .cmp_mode_i(cmp_mode_i),
  .act_code_i(act_code_i), .force_i(force_i), .lead_mask_i(lead_mask_i),
  .lead_data_i(lead_data_i), .tog_ovf_i(tog_ovf_i), .irq_en_i(irq_en_i),
  .flag_clr_i(flag_clr_i), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/oc_pin_action_unit_tb.sv
`timescale 1ns/1ps
module oc_pin_action_unit_tb_top;
  localparam int NCH = 8;
  localparam int CW  = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic [CW-1:0]     count_i = '0;
  logic              tick_i = 1'b0, ovf_i = 1'b0;
  logic [NCH*CW-1:0] cmp_val_i = '1;
  logic [NCH-1:0]    cmp_mode_i = '1;
  logic [2*NCH-1:0]  act_code_i = '0;
  logic [NCH-1:0]    force_i = '0, lead_mask_i = '0, lead_data_i = '0;
  logic [NCH-1:0]    tog_ovf_i = '0, irq_en_i = '0, flag_clr_i = '0;
  logic [NCH-1:0]    pin_o, pin_oe_o, flag_o;
  logic              irq_o;

  oc_pin_action_unit #(.NCH(NCH), .CW(CW)) dut_i (.*);

  typedef struct {
    logic [NCH-1:0] pin, oe, flag;
    logic           irq;
    string          tag;
  } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_bad = 0;
  logic [NCH-1:0] m_pin = '0, m_flag = '0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model from requirements, pushes the expected result of this cycle
  task automatic cycle(string tag);
    exp_t e;
    logic [NCH-1:0] mt, ev, np, oe;
    for (int i = 0; i < NCH; i++) begin
      mt[i] = cmp_mode_i[i] && tick_i && (count_i == cmp_val_i[CW*i +: CW]);
      ev[i] = cmp_mode_i[i] && (mt[i] || force_i[i]);
    end
    np = m_pin;
    for (int i = 0; i < NCH; i++) begin
      logic [1:0] c;
      c = act_code_i[2*i +: 2];
      oe[i] = (c != 2'b00) || lead_mask_i[i];
      if (ev[NCH-1] && lead_mask_i[i]) np[i] = lead_data_i[i];
      else if (ev[i] && c == 2'b01) np[i] = ~m_pin[i];
      else if (ev[i] && c == 2'b10) np[i] = 1'b0;
      else if (ev[i] && c == 2'b11) np[i] = 1'b1;
      else if (ovf_i && tog_ovf_i[i]) np[i] = ~m_pin[i];
    end
    m_flag = mt | (m_flag & ~flag_clr_i);
    m_pin  = np;
    e.pin = np; e.oe = oe; e.flag = m_flag; e.irq = |(m_flag & irq_en_i); e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    tick_i = 0; ovf_i = 0; force_i = '0; flag_clr_i = '0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " pin"},  32'(pin_o),    32'(e.pin));
        chk({e.tag, " oe"},   32'(pin_oe_o), 32'(e.oe));
        chk({e.tag, " flag"}, 32'(flag_o),   32'(e.flag));
        chk({e.tag, " irq"},  32'(irq_o),    32'(e.irq));
      end
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic set_cmp(int ch, logic [CW-1:0] v);
    cmp_val_i[CW*ch +: CW] = v;
  endtask
  task automatic set_act(int ch, logic [1:0] c);
    act_code_i[2*ch +: 2] = c;
  endtask

  initial begin
    #1;
    chk("R11 reset pins", 32'(pin_o), 0);
    chk("R11 reset flags", 32'(flag_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1: toggle / clear / set codes; ch3 code 00 (R2)
    set_act(0, 2'b01); set_act(1, 2'b10); set_act(2, 2'b11); set_act(3, 2'b00);
    for (int i = 0; i < 4; i++) set_cmp(i, 16'd10);
    count_i = 16'd10; tick_i = 1;
    cycle("R1 R2 R3 match actions");

    // R4: held count without tick
    cycle("R4 held count no repeat");

    // R3: set wins over clear; ch0 matches again while all flags cleared
    count_i = 16'd10; tick_i = 1; flag_clr_i = 8'h0F;
    cmp_mode_i[1] = 0; cmp_mode_i[2] = 0; cmp_mode_i[3] = 0;
    cycle("R3 set over clear");
    flag_clr_i = 8'hFF;
    cycle("R3 clear");
    cmp_mode_i = '1;

    // R5: force without flag
    force_i = 8'h05;
    cycle("R5 force no flag");

    // R9: capture channel ignores match and force
    cmp_mode_i[2] = 0; set_act(2, 2'b10);
    count_i = 16'd10; tick_i = 1;
    cycle("R9 capture match");
    force_i[2] = 1;
    cycle("R9 capture force");

    // R6 R7: lead channel masked drive beats own toggle on pin0
    set_cmp(0, 16'd20); set_cmp(7, 16'd20); set_act(7, 2'b11);
    lead_mask_i = 8'h0F; lead_data_i = 8'h04;
    count_i = 16'd20; tick_i = 1;
    cycle("R6 R7 lead drive");

    // R9: lead channel in capture mode drives no masked pins
    cmp_mode_i[7] = 0; lead_data_i = 8'h0B;
    count_i = 16'd20; tick_i = 1;
    cycle("R9 lead capture");
    cmp_mode_i[7] = 1;
    force_i[7] = 1;
    cycle("R6 lead force");
    lead_mask_i = '0;

    // R8: overflow toggle on a code-00 pin (R2 oe low)
    tog_ovf_i = 8'h12; set_act(1, 2'b11); set_cmp(1, 16'd0);
    ovf_i = 1;
    cycle("R8 R2 overflow toggle");
    ovf_i = 1; count_i = 16'd0; tick_i = 1;
    cycle("R8 compare beats overflow");
    tog_ovf_i = '0;

    // R10: interrupt masking
    irq_en_i = 8'h20;
    cycle("R10 masked irq");
    irq_en_i = 8'h02;
    cycle("R10 enabled irq");
    irq_en_i = '0;

    // R4: equal count without tick leaves everything
    count_i = 16'd20; flag_clr_i = '1;
    cycle("R4 clear then");
    count_i = 16'd20;
    cycle("R4 no tick no flag");

    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule